// File: doc/BRIEF.md
# Tile Background Pixel Fetcher

This block produces one background layer for a 128x128 tile-mapped display. It runs in step with an 8-bit horizontal and an 8-bit vertical pixel counter. Each counter spans 256 positions, and only values below 128 are visible. The screen is covered by a 16x16 grid of 8x8-pixel tiles. Every grid entry is two bytes in video memory: a tile number and a palette number. Tile rows hold either one bit plane (two colours) or two bit planes (four colours) per pixel.

For every 8-pixel span, the block fetches the next tile through a single read port to video memory. The port has one-cycle latency and carries at most one access per tick. The fetch follows a fixed schedule that is set by the low three bits of the horizontal counter. The fetched row bytes are loaded into plane shift registers just before the tile's leftmost pixel. The bits shifted out, together with the palette number, address a 64-byte colour RAM. A separate write port fills the colour RAM. The colour byte is expanded to 9-bit RGB. The first tile of every line is fetched during the last span of the previous line, so column 0 is correct.

Top module: `tile_bg_fetch`

## Requirements
- R1: In the span ending at hcount h|7, the block fetches the tile whose leftmost pixel is at column ((h>>3)+1) mod 16. That tile is on line v, or on line v+1 mod 256 when h>=248. The block reads grid byte (grid_base + 16*(line>>3 mod 16) + column) mod 8192 at phase 0 (hcount[2:0]=0), and reads the following address at phase 1.
- R2: The first grid byte is the tile index. Bits 3:0 of the second grid byte are the palette number, and bits 7:4 have no effect on any pixel.
- R3: vram_rd_o is high at phases 0, 1 and 2, and at phase 3 only in 2-bit mode. It is low at phases 4 to 7. Read data is taken from vram_data_i one tick after the address.
- R4: In 1-bit mode (depth2_i=0), the tile row is read at tile_base + 8*tile + (line mod 8). The colour RAM address is 2*palette + bit.
- R5: In 2-bit mode (depth2_i=1), plane 0 is read at tile_base + 16*tile + 2*(line mod 8) and plane 1 at the next address. The colour index is {plane1 bit, plane0 bit}, and the colour RAM address is 4*palette + index.
- R6: Bit 7 of each row byte is the leftmost pixel of the tile, and bit 0 is the rightmost.
- R7: The colour byte {B1,B0,G2,G1,G0,R2,R1,R0} is output as rgb_o = {B1,B0,0,G2,G1,G0,R2,R1,R0}.
- R8: rgb_o and pix_valid_o describe the counter values presented one tick earlier. pix_valid_o is high exactly when those values were both below 128.
- R9: Pixel 0 of every line, including line 0 after line 255, shows the tile of grid column 0 of that line.
- R10: The colour RAM has 64 bytes. A write through cram_we_i is seen by pixel reads from the following tick onward.
- R11: While rst_ni is low, pix_valid_o is 0 and rgb_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hcount_i | input | 8 | Horizontal pixel counter |
| vcount_i | input | 8 | Vertical pixel counter |
| grid_base_i | input | 13 | Video memory address of the grid |
| tile_base_i | input | 13 | Video memory address of tile 0 |
| depth2_i | input | 1 | 1 selects two bit planes, 0 selects one |
| vram_addr_o | output | 13 | Video memory read address |
| vram_rd_o | output | 1 | Video memory read strobe |
| vram_data_i | input | 8 | Read data, one tick after the address |
| cram_we_i | input | 1 | Colour RAM write enable |
| cram_waddr_i | input | 6 | Colour RAM write address |
| cram_wdata_i | input | 8 | Colour RAM write data |
| rgb_o | output | 9 | Pixel colour {blue3, green3, red3} |
| pix_valid_o | output | 1 | Pixel lies in the visible area |

## Verification
The properties assume that the counters advance by one per tick when they change. They also assume that depth2_i changes only at the start of a span (phase 0), never in its middle, so the fetch schedule seen at phase 3 matches the mode in force. The stimulus runs consecutive counter values over whole lines. Between line groups it jumps only from a phase-7 blanking position to a phase-0 position, and it changes the bases, the mode, video memory and the colour RAM only at that point.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  localparam int PAL_W   = 4;
  localparam int NPLANES = 2;

  typedef struct packed {
    logic [7:0]       plane1;
    logic [7:0]       plane0;
    logic [PAL_W-1:0] pal;
    logic             d2;
  } tile_row_t;

  // BBGGGRRR -> {BB0, GGG, RRR}
  function automatic logic [8:0] expand_color(input logic [7:0] c);
    return {c[7:6], 1'b0, c[5:3], c[2:0]};
  endfunction
endpackage

// File: rtl/tbg_fetch_seq.sv
module tbg_fetch_seq
  import tbg_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    hcount_i,
  input  logic [7:0]    vcount_i,
  input  logic [AW-1:0] grid_base_i,
  input  logic [AW-1:0] tile_base_i,
  input  logic          depth2_i,
  output logic [AW-1:0] vram_addr_o,
  output logic          vram_rd_o,
  input  logic [7:0]    vram_data_i,
  output logic          load_o,
  output tile_row_t     row_o
);
  localparam logic [2:0] PH_GRID0 = 3'd0;
  localparam logic [2:0] PH_GRID1 = 3'd1;
  localparam logic [2:0] PH_ROW0  = 3'd2;
  localparam logic [2:0] PH_ROW1  = 3'd3;
  localparam logic [2:0] PH_CAP1  = 3'd4;
  localparam logic [2:0] PH_LOAD  = 3'd7;

  logic [2:0]       ph;
  logic [3:0]       col_n;
  logic [7:0]       line_n;
  logic [AW-1:0]    grid_a;
  logic [AW-1:0]    tile_a;

  logic [AW-1:0]    gaddr_q;
  logic [2:0]       ry_q;
  logic             d2_q;
  logic [7:0]       tidx_q;
  logic [PAL_W-1:0] pal_q;
  logic [7:0]       p0_q;
  logic [7:0]       p1_q;

  assign ph     = hcount_i[2:0];
  assign col_n  = hcount_i[6:3] + 4'd1;
  // last span of a line prefetches column 0 of the next line
  assign line_n = (&hcount_i[7:3]) ? vcount_i + 8'd1 : vcount_i;
  assign grid_a = grid_base_i + AW'({line_n[6:3], col_n});

  always_comb begin
    if (d2_q) tile_a = tile_base_i + (AW'(tidx_q) << 4) + AW'({ry_q, 1'b0});
    else      tile_a = tile_base_i + (AW'(tidx_q) << 3) + AW'(ry_q);
  end

  always_comb begin
    vram_addr_o = gaddr_q;
    vram_rd_o   = 1'b0;
    unique case (ph)
      PH_GRID0: begin vram_addr_o = grid_a;            vram_rd_o = 1'b1; end
      PH_GRID1: begin vram_addr_o = gaddr_q + AW'(1);  vram_rd_o = 1'b1; end
      PH_ROW0:  begin vram_addr_o = tile_a;            vram_rd_o = 1'b1; end
      PH_ROW1:  begin vram_addr_o = tile_a + AW'(1);   vram_rd_o = d2_q; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gaddr_q <= '0;
      ry_q    <= '0;
      d2_q    <= 1'b0;
      tidx_q  <= '0;
      pal_q   <= '0;
      p0_q    <= '0;
      p1_q    <= '0;
    end else begin
      unique case (ph)
        PH_GRID0: begin
          gaddr_q <= grid_a;
          ry_q    <= line_n[2:0];
          d2_q    <= depth2_i;
        end
        PH_GRID1: tidx_q <= vram_data_i;
        PH_ROW0:  pal_q  <= vram_data_i[PAL_W-1:0];
        PH_ROW1:  p0_q   <= vram_data_i;
        PH_CAP1:  p1_q   <= d2_q ? vram_data_i : 8'h00;
        default:  ;
      endcase
    end
  end

  assign load_o     = (ph == PH_LOAD);
  assign row_o.plane0 = p0_q;
  assign row_o.plane1 = p1_q;
  assign row_o.pal    = pal_q;
  assign row_o.d2     = d2_q;
endmodule

// File: rtl/tbg_shifter.sv
module tbg_shifter
  import tbg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  tile_row_t        row_i,
  output logic [NPLANES-1:0] cidx_o,
  output logic [PAL_W-1:0] pal_o,
  output logic             d2_o
);
  logic [7:0] src [NPLANES];
  assign src[0] = row_i.plane0;
  assign src[1] = row_i.plane1;

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [7:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q <= '0;
      else if (load_i) sh_q <= src[p];
      else             sh_q <= {sh_q[6:0], 1'b0};
    end
    assign cidx_o[p] = sh_q[7];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pal_o <= '0;
      d2_o  <= 1'b0;
    end else if (load_i) begin
      pal_o <= row_i.pal;
      d2_o  <= row_i.d2;
    end
  end
endmodule

// File: rtl/tbg_cram.sv
module tbg_cram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/tile_bg_fetch.sv
module tile_bg_fetch
  import tbg_pkg::*;
#(
  parameter int VAW        = 13,
  parameter int CRAM_DEPTH = 64,
  localparam int CAW       = $clog2(CRAM_DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [7:0]     hcount_i,
  input  logic [7:0]     vcount_i,
  input  logic [VAW-1:0] grid_base_i,
  input  logic [VAW-1:0] tile_base_i,
  input  logic           depth2_i,
  output logic [VAW-1:0] vram_addr_o,
  output logic           vram_rd_o,
  input  logic [7:0]     vram_data_i,
  input  logic           cram_we_i,
  input  logic [CAW-1:0] cram_waddr_i,
  input  logic [7:0]     cram_wdata_i,
  output logic [8:0]     rgb_o,
  output logic           pix_valid_o
);
  tile_row_t          row;
  logic               load;
  logic [NPLANES-1:0] cidx;
  logic [PAL_W-1:0]   pal;
  logic               d2;
  logic [CAW-1:0]     craddr;
  logic [7:0]         cdata;
  logic               valid_q;

  tbg_fetch_seq #(.AW(VAW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hcount_i    (hcount_i),
    .vcount_i    (vcount_i),
    .grid_base_i (grid_base_i),
    .tile_base_i (tile_base_i),
    .depth2_i    (depth2_i),
    .vram_addr_o (vram_addr_o),
    .vram_rd_o   (vram_rd_o),
    .vram_data_i (vram_data_i),
    .load_o      (load),
    .row_o       (row)
  );

  tbg_shifter u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .row_i  (row),
    .cidx_o (cidx),
    .pal_o  (pal),
    .d2_o   (d2)
  );

  always_comb begin
    if (d2) craddr = CAW'({pal, cidx});
    else    craddr = CAW'({pal, cidx[0]});
  end

  tbg_cram #(.DEPTH(CRAM_DEPTH), .DW(8)) u_cram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cram_we_i),
    .waddr_i (cram_waddr_i),
    .wdata_i (cram_wdata_i),
    .raddr_i (craddr),
    .rdata_o (cdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= ~hcount_i[7] & ~vcount_i[7];
  end

  assign rgb_o       = expand_color(cdata);
  assign pix_valid_o = valid_q;
endmodule

// File: rtl/tile_bg_fetch_chk.sv
module tile_bg_fetch_chk #(
  parameter int VAW = 13
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [7:0]     hcount_i,
  input logic [7:0]     vcount_i,
  input logic           depth2_i,
  input logic [VAW-1:0] vram_addr_o,
  input logic           vram_rd_o,
  input logic           pix_valid_o
);
  logic [2:0] ph;
  logic       live_q;
  assign ph = hcount_i[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_RD_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph < 3'd3) |-> vram_rd_o); // R3
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph > 3'd3) |-> !vram_rd_o); // R3
  AST_RD_ONEBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == 3'd3 && !depth2_i) |-> !vram_rd_o); // R4
  AST_GRID_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && ph == 3'd1) |-> (vram_addr_o == $past(vram_addr_o) + VAW'(1))); // R1
  AST_PLANE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && ph == 3'd3 && depth2_i) |-> (vram_addr_o == $past(vram_addr_o) + VAW'(1))); // R5
  AST_VALID_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(hcount_i[7] | vcount_i[7])) |-> !pix_valid_o); // R8
  AST_VALID_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!hcount_i[7] && !vcount_i[7])) |-> pix_valid_o); // R8
endmodule

bind tile_bg_fetch tile_bg_fetch_chk #(.VAW(VAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hcount_i    (hcount_i),
  .vcount_i    (vcount_i),
  .depth2_i    (depth2_i),
  .vram_addr_o (vram_addr_o),
  .vram_rd_o   (vram_rd_o),
  .pix_valid_o (pix_valid_o)
);

// File: tb/tile_bg_fetch_tb.sv
module tile_bg_fetch_tb;
  localparam int CLK_P = 10;
  localparam int VMW   = 2048;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  hcount = 8'd200;
  logic [7:0]  vcount = 8'd200;
  logic [12:0] gbase = '0;
  logic [12:0] tbase = '0;
  logic        d2 = 1'b0;
  logic [12:0] vaddr;
  logic        vrd;
  logic [7:0]  vdata = '0;
  logic        cwe = 1'b0;
  logic [5:0]  cwa = '0;
  logic [7:0]  cwd = '0;
  logic [8:0]  rgb;
  logic        pvalid;

  logic [7:0] vmem  [VMW];
  logic [7:0] cshad [64];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  tile_bg_fetch u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .hcount_i (hcount), .vcount_i (vcount),
    .grid_base_i (gbase), .tile_base_i (tbase), .depth2_i (d2),
    .vram_addr_o (vaddr), .vram_rd_o (vrd), .vram_data_i (vdata),
    .cram_we_i (cwe), .cram_waddr_i (cwa), .cram_wdata_i (cwd),
    .rgb_o (rgb), .pix_valid_o (pvalid)
  );

  // video memory model, one-cycle latency, aliased to VMW bytes
  always @(posedge clk) vdata <= vmem[vaddr[10:0]];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (h=%0d v=%0d)",
               tag, what, act, exp, hcount, vcount);
    end
  endtask

  function automatic logic [7:0] vm(input int a);
    return vmem[(a & 8191) & (VMW-1)];
  endfunction

  function automatic int grid_addr(input int col, input int line);
    return (int'(gbase) + 16 * ((line >> 3) & 15) + (col & 15)) & 8191;
  endfunction

  function automatic int row_addr(input int ti, input int line);
    if (d2) return (int'(tbase) + ti * 16 + (line & 7) * 2) & 8191;
    else    return (int'(tbase) + ti * 8 + (line & 7)) & 8191;
  endfunction

  function automatic logic [8:0] exp_pix(input int h, input int v);
    int ga, ti, pal, ra, ci, ca;
    logic [7:0] p0, p1, c;
    ga  = grid_addr(h >> 3, v);
    ti  = vm(ga);
    pal = vm(ga + 1) & 15;            // R2: upper nibble ignored
    ra  = row_addr(ti, v);
    p0  = vm(ra);
    p1  = vm(ra + 1);
    if (d2) begin                     // R5
      ci = {p1[7 - (h & 7)], p0[7 - (h & 7)]};   // R6: bit 7 leftmost
      ca = pal * 4 + ci;
    end else begin                    // R4
      ci = p0[7 - (h & 7)];
      ca = pal * 2 + ci;
    end
    c = cshad[ca];
    return {c[7:6], 1'b0, c[5:0]};    // R7
  endfunction

  task automatic cram_write(input int a, input logic [7:0] d);
    @(negedge clk);
    cwe = 1'b1; cwa = a[5:0]; cwd = d;
    @(negedge clk);
    cwe = 1'b0;
    cshad[a] = d;                     // R10
  endtask

  task automatic tick();
    int h, v, line_n, col_n, ga;
    bit exp_rd;
    h = hcount; v = vcount;
    #1;
    exp_rd = (h & 7) < 3 || ((h & 7) == 3 && d2);
    chk(vrd == exp_rd, "R3", "vram_rd", vrd, exp_rd);
    line_n = (h >= 248) ? ((v + 1) & 255) : v;
    col_n  = ((h >> 3) + 1) & 15;
    ga     = grid_addr(col_n, line_n);
    if ((h & 7) == 0) chk(vaddr == ga, "R1", "grid addr", vaddr, ga);
    if ((h & 7) == 2) chk(vaddr == row_addr(vm(ga), line_n), d2 ? "R5" : "R4",
                          "row addr", vaddr, row_addr(vm(ga), line_n));
    @(negedge clk);
    if (h < 128 && v < 128) begin
      chk(pvalid == 1'b1, "R8", "valid active", pvalid, 1);
      chk(rgb == exp_pix(h, v), (h == 0) ? "R9" : (d2 ? "R5" : "R4"),
          "rgb", rgb, exp_pix(h, v));
    end else begin
      chk(pvalid == 1'b0, "R8", "valid blank", pvalid, 0);
    end
    h = h + 1;
    if (h == 256) begin h = 0; v = (v + 1) & 255; end
    hcount = h[7:0]; vcount = v[7:0];
  endtask

  // runs from (vs-1, 240) through (vs+lines-1, 199)
  task automatic run_seg(input int vs, input int lines, input bit mode,
                         input bit wrap_tiles);
    int vend;
    for (int i = 0; i < VMW; i++) vmem[i] = 8'($urandom);
    if (wrap_tiles) begin
      tbase = 13'h1FF8;
      for (int i = 0; i < VMW; i += 2) vmem[i] = 8'hFF;
    end else begin
      tbase = 13'($urandom);
    end
    gbase = 13'($urandom);
    d2 = mode;
    for (int k = 0; k < 4; k++) cram_write($urandom % 64, 8'($urandom));
    vend   = (vs + lines - 1) & 255;
    hcount = 8'd240;
    vcount = 8'((vs - 1) & 255);
    while (!(hcount == 8'd199 && vcount == vend[7:0])) tick();
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < VMW; i++) vmem[i] = '0;
    for (int i = 0; i < 64; i++) cshad[i] = '0;
    repeat (3) @(negedge clk);
    chk(pvalid == 1'b0, "R11", "valid in reset", pvalid, 0);
    chk(rgb == 9'd0, "R11", "rgb in reset", rgb, 0);
    rst_ni = 1'b1;
    hcount = 8'd199; vcount = 8'd200;
    for (int i = 0; i < 64; i++) cram_write(i, 8'($urandom));
    run_seg(0, 3, 1'b0, 1'b0);        // R9 line 255 -> 0, 1-bit
    run_seg(5, 3, 1'b1, 1'b0);        // 2-bit
    run_seg(125, 4, 1'b1, 1'b0);      // R8 edge into vertical blank
    run_seg(64, 2, 1'b1, 1'b1);       // tile 255, base wrap
    run_seg(30, 2, 1'b0, 1'b1);
    for (int s = 0; s < 8; s++)
      run_seg($urandom % 128, 2, 1'($urandom), 1'b0);
    // R10: recolour one entry and use it right away
    cram_write(0, 8'hC7);
    run_seg(8, 1, 1'b0, 1'b0);
    finish_run();
  end
endmodule